// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This block is a memory-mapped real-time clock. A prescaler divides the reference clock (nominally 32.768 kHz) down to a one-cycle tick once per second. Each tick advances a 32-bit seconds counter. Software can read and load this counter at any time. A 32-bit alarm compare value is checked against the counter as it advances, and a match sets a sticky alarm flag.

A status register holds two event flags: one for the second tick and one for the alarm. Beside them sit two interrupt enables. The flags are cleared by writing ones to them. Two level interrupt outputs are formed from each flag and its enable.

The prescaler word carries a 16-bit divide count in its low half and a 10-bit trim field above it. The trim field shortens one second out of every 1024 by the trim value, which corrects slow drift. When the whole word is zero, the prescaler uses the default divide count of 32767.

The register interface is a single-cycle synchronous bus on the reference clock. A write happens on a clock edge while `bus_en` and `bus_we` are high. Read data is a combinational function of `bus_addr`.

Top module: `rtc_seconds_alarm`

## Requirements
- R1: Register offsets and readback are as follows. The alarm value sits at 0x00, the seconds counter at 0x04, the prescaler word at 0x08 and the status register at 0x10. The prescaler word reads back the divide count in bits 15:0 and the trim in bits 25:16, with all higher bits reading 0. Status bits above bit 3 read 0, and every other offset reads 0.
- R2: After reset, every register reads zero and both interrupt outputs are low.
- R3: After a write to the prescaler word with divide count D, the first tick comes D+1 clock edges after the write edge. Ticks then repeat every D+1 edges. Each tick adds one to the seconds counter, which wraps from 0xFFFFFFFF to 0.
- R4: When the prescaler word is zero, the period is 32768 edges. This holds both out of reset and after software writes zero.
- R5: The trim phase restarts when the prescaler word is written. The second that ends with the 1024th tick after that write, and every 1024th one after it, is shortened by the trim value. It lasts D+1-T edges, or a single edge when T is D or larger.
- R6: A write to 0x04 loads the seconds counter, and reads return the current count. A load on the same edge as a tick wins over the increment.
- R7: Status bit 0 (the alarm flag) sets on the tick that makes the counter equal to the alarm value. It stays set while the counter moves on, whatever bit 2 holds. A software load of a matching value does not set it.
- R8: Status bit 1 (the tick flag) sets on every tick.
- R9: Writing 1 to status bit 0 or bit 1 clears that flag, and writing 0 leaves it unchanged. If a clear and a new event fall on the same edge, the flag ends up set.
- R10: Status bit 2 (alarm interrupt enable) and bit 3 (tick interrupt enable) are plain read/write bits.
- R11: `irq_alarm` is high exactly while bits 0 and 2 are both set. `irq_tick` is high exactly while bits 1 and 3 are both set. Both are levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the bus also runs on it |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write qualifier for the access |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_tick | output | 1 | Second-tick interrupt level |
| irq_alarm | output | 1 | Alarm interrupt level |

## Verification
The prescaler is driven with the zero word twice, once out of reset and once written. This separates a reset-only default from a true zero-word fallback. It is also driven with a short divide count, which exposes any off-by-one in the D+1 period. A trim smaller than the divide count and a trim larger than it are each run across a full 1024-second phase. The bench checks that only the last second shrinks, and that the larger trim saturates to one edge. The alarm is hit through a counter wrap from 0xFFFFFFFF to 0, and is then approached by a software load. The second case tells a tick-qualified match apart from a plain equality compare. Counter loads and flag clears are timed to land on a tick edge, to pin down which side wins.

// File: rtl/rtc_sa_pkg.sv
package rtc_sa_pkg;

    localparam logic [31:0] OFF_ALARM = 32'h00;
    localparam logic [31:0] OFF_COUNT = 32'h04;
    localparam logic [31:0] OFF_PRESC = 32'h08;
    localparam logic [31:0] OFF_STAT  = 32'h10;

    // bit 3 tick enable, bit 2 alarm enable, bit 1 tick flag, bit 0 alarm flag
    typedef struct packed {
        logic tick_en;
        logic alarm_en;
        logic tick_flag;
        logic alarm_flag;
    } stat_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ALARM,
        SEL_COUNT,
        SEL_PRESC,
        SEL_STAT
    } sel_e;

    function automatic sel_e decode_sel(input logic [31:0] addr);
        sel_e s;
        case (addr)
            OFF_ALARM: s = SEL_ALARM;
            OFF_COUNT: s = SEL_COUNT;
            OFF_PRESC: s = SEL_PRESC;
            OFF_STAT:  s = SEL_STAT;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rtc_sa_prescaler.sv
module rtc_sa_prescaler #(
    parameter int DIV_W       = 16,
    parameter int TRIM_W      = 10,
    parameter int TRIM_PERIOD = 1024,
    parameter int DEF_DIV     = 32767
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              use_default,
    input  logic [DIV_W-1:0]  div_cfg,
    input  logic [TRIM_W-1:0] trim_cfg,
    output logic              tick_o
);
    localparam int PH_W = $clog2(TRIM_PERIOD);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(TRIM_PERIOD - 1);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] eff_div;
    logic [DIV_W-1:0] trim_ext;
    logic [DIV_W-1:0] limit;
    logic [PH_W-1:0]  phase_q;
    logic             last_sec;

    always_comb begin
        eff_div  = use_default ? DIV_W'(DEF_DIV) : div_cfg;
        trim_ext = DIV_W'(trim_cfg);
        last_sec = (phase_q == PH_LAST);
        if (last_sec)
            limit = (eff_div > trim_ext) ? (eff_div - trim_ext) : '0;
        else
            limit = eff_div;
    end

    assign tick_o = (cnt_q == limit) && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q   <= '0;
            phase_q <= '0;
        end else if (tick_o) begin
            cnt_q   <= '0;
            phase_q <= last_sec ? '0 : phase_q + PH_W'(1);
        end else begin
            cnt_q   <= cnt_q + DIV_W'(1);
        end
    end

    // R3
    tick_restart_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> (cnt_q == '0));
    // R3
    cfg_restart_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt_q == '0 && phase_q == '0));
    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= eff_div);

endmodule

// File: rtl/rtc_sa_seconds.sv
module rtc_sa_seconds #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             cnt_we,
    input  logic             alarm_we,
    input  logic [SEC_W-1:0] wdata,
    output logic [SEC_W-1:0] count_o,
    output logic [SEC_W-1:0] alarm_o,
    output logic             alarm_hit_o
);
    logic [SEC_W-1:0] count_q;
    logic [SEC_W-1:0] alarm_q;
    logic [SEC_W-1:0] next_count;

    assign next_count  = count_q + SEC_W'(1);
    assign alarm_hit_o = tick && !cnt_we && (next_count == alarm_q);
    assign count_o     = count_q;
    assign alarm_o     = alarm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            alarm_q <= '0;
        end else begin
            if (cnt_we)
                count_q <= wdata;
            else if (tick)
                count_q <= next_count;
            if (alarm_we)
                alarm_q <= wdata;
        end
    end

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_we) |=> (count_q == $past(count_q) + SEC_W'(1)));
    // R6
    count_load_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_we |=> (count_q == $past(wdata)));
    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_we) |=> $stable(count_q));
    // R7
    alarm_match_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_hit_o |=> (count_q == $past(alarm_q)));

endmodule

// File: rtl/rtc_sa_status.sv
module rtc_sa_status
    import rtc_sa_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  stat_t wdata,
    input  logic  tick_evt,
    input  logic  alarm_evt,
    output stat_t stat_o,
    output logic  irq_tick_o,
    output logic  irq_alarm_o
);
    stat_t stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            if (wr) begin
                stat_q.tick_en  <= wdata.tick_en;
                stat_q.alarm_en <= wdata.alarm_en;
            end
            stat_q.tick_flag  <= tick_evt  | (stat_q.tick_flag  & ~(wr & wdata.tick_flag));
            stat_q.alarm_flag <= alarm_evt | (stat_q.alarm_flag & ~(wr & wdata.alarm_flag));
        end
    end

    assign stat_o      = stat_q;
    assign irq_tick_o  = stat_q.tick_flag  & stat_q.tick_en;
    assign irq_alarm_o = stat_q.alarm_flag & stat_q.alarm_en;

    // R7
    alarm_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q.alarm_flag) |-> $past(alarm_evt));
    // R7
    alarm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_q.alarm_flag && !(wr && wdata.alarm_flag)) |=> stat_q.alarm_flag);
    // R8
    tick_flag_chk: assert property (@(posedge clk) disable iff (rst)
        tick_evt |=> stat_q.tick_flag);
    // R9
    tick_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && wdata.tick_flag && !tick_evt) |=> !stat_q.tick_flag);

endmodule

// File: rtl/rtc_seconds_alarm.sv
module rtc_seconds_alarm
    import rtc_sa_pkg::*;
#(
    parameter int SEC_W       = 32,
    parameter int ADDR_W      = 5,
    parameter int DIV_W       = 16,
    parameter int TRIM_W      = 10,
    parameter int TRIM_PERIOD = 1024,
    parameter int DEF_DIV     = 32767
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SEC_W-1:0]  bus_wdata,
    output logic [SEC_W-1:0]  bus_rdata,
    output logic              irq_tick,
    output logic              irq_alarm
);
    localparam int TRIM_LSB = DIV_W;
    localparam int STAT_W   = $bits(stat_t);

    sel_e             sel;
    logic             wr;
    logic [DIV_W-1:0] div_q;
    logic [TRIM_W-1:0] trim_q;
    logic             use_default;
    logic             tick;
    logic             alarm_hit;
    logic [SEC_W-1:0] count;
    logic [SEC_W-1:0] alarm_val;
    stat_t            stat;

    assign sel         = decode_sel(32'(bus_addr));
    assign wr          = bus_en && bus_we;
    assign use_default = (div_q == '0) && (trim_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            trim_q <= '0;
        end else if (wr && sel == SEL_PRESC) begin
            div_q  <= bus_wdata[DIV_W-1:0];
            trim_q <= bus_wdata[TRIM_LSB +: TRIM_W];
        end
    end

    rtc_sa_prescaler #(
        .DIV_W(DIV_W), .TRIM_W(TRIM_W),
        .TRIM_PERIOD(TRIM_PERIOD), .DEF_DIV(DEF_DIV)
    ) u_presc (
        .clk(clk), .rst(rst),
        .restart(wr && sel == SEL_PRESC),
        .use_default(use_default),
        .div_cfg(div_q), .trim_cfg(trim_q),
        .tick_o(tick)
    );

    rtc_sa_seconds #(.SEC_W(SEC_W)) u_secs (
        .clk(clk), .rst(rst), .tick(tick),
        .cnt_we(wr && sel == SEL_COUNT),
        .alarm_we(wr && sel == SEL_ALARM),
        .wdata(bus_wdata),
        .count_o(count), .alarm_o(alarm_val),
        .alarm_hit_o(alarm_hit)
    );

    rtc_sa_status u_stat (
        .clk(clk), .rst(rst),
        .wr(wr && sel == SEL_STAT),
        .wdata(stat_t'(bus_wdata[STAT_W-1:0])),
        .tick_evt(tick), .alarm_evt(alarm_hit),
        .stat_o(stat),
        .irq_tick_o(irq_tick), .irq_alarm_o(irq_alarm)
    );

    always_comb begin
        case (sel)
            SEL_ALARM: bus_rdata = alarm_val;
            SEL_COUNT: bus_rdata = count;
            SEL_PRESC: bus_rdata = SEC_W'({trim_q, div_q});
            SEL_STAT:  bus_rdata = SEC_W'(stat);
            default:   bus_rdata = '0;
        endcase
    end

    // R11
    irq_alarm_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_alarm |-> (stat.alarm_en && stat.alarm_flag));
    // R11
    irq_tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_tick |-> (stat.tick_en && stat.tick_flag));

endmodule

// File: tb/rtc_seconds_alarm_test.sv
module rtc_seconds_alarm_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_tick;
    logic        irq_alarm;

    int checks = 0;
    int errors = 0;
    int edges  = 0;
    int mark   = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    rtc_seconds_alarm uut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_tick(irq_tick), .irq_alarm(irq_alarm)
    );

    always @(posedge clk) begin
        edges <= edges + 1;
        if (edges > 190000 && !done) begin
            errors++;
            $display("FAIL watchdog expired at edge %0d", edges);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_until(input int k);
        while ((edges - mark) < k) @(negedge clk);
    endtask

    task automatic t_reset_default;
        logic [31:0] d;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        mark = edges;
        bus_read(5'h00, d); chk("R2 alarm after reset", d, 0);
        bus_read(5'h04, d); chk("R2 count after reset", d, 0);
        bus_read(5'h08, d); chk("R2 prescaler after reset", d, 0);
        bus_read(5'h10, d); chk("R2 status after reset", d, 0);
        chk("R2 irq_tick after reset", {31'b0, irq_tick}, 0);
        chk("R2 irq_alarm after reset", {31'b0, irq_alarm}, 0);
        wait_until(32767);
        bus_read(5'h04, d); chk("R4 default divide before tick", d, 0);
        wait_until(32768);
        bus_read(5'h04, d); chk("R4 default divide first tick", d, 1);
        bus_read(5'h10, d); chk("R8 tick flag after tick", d, 32'h2);
        chk("R11 irq_tick masked", {31'b0, irq_tick}, 0);
    endtask

    task automatic t_map;
        logic [31:0] d;
        bus_write(5'h08, 32'hFFFF_FFFF);
        bus_read(5'h08, d); chk("R1 prescaler readback", d, 32'h03FF_FFFF);
        bus_write(5'h00, 32'hA5A5_1234);
        bus_read(5'h00, d); chk("R1 alarm readback", d, 32'hA5A5_1234);
        bus_write(5'h10, 32'hFFFF_FFFC);
        bus_read(5'h10, d); chk("R10 enables set, flags kept", d, 32'hE);
        bus_write(5'h10, 32'h0000_0002);
        bus_read(5'h10, d); chk("R9 tick flag cleared", d, 32'h0);
        bus_read(5'h0C, d); chk("R1 unmapped 0x0C", d, 0);
        bus_read(5'h14, d); chk("R1 unmapped 0x14", d, 0);
    endtask

    task automatic t_period_load;
        logic [31:0] d;
        bus_write(5'h08, 32'h0000_0003);
        mark = edges;
        bus_write(5'h04, 32'h0);
        wait_until(3); bus_read(5'h04, d); chk("R3 before first tick", d, 0);
        wait_until(4); bus_read(5'h04, d); chk("R3 first tick", d, 1);
        wait_until(7); bus_read(5'h04, d); chk("R3 before second tick", d, 1);
        wait_until(8); bus_read(5'h04, d); chk("R3 second tick", d, 2);
        wait_until(11);
        bus_write(5'h04, 32'd100);
        bus_read(5'h04, d); chk("R6 load wins over tick", d, 100);
        wait_until(15); bus_read(5'h04, d); chk("R6 hold after load", d, 100);
        wait_until(16); bus_read(5'h04, d); chk("R6 count from loaded value", d, 101);
    endtask

    task automatic t_alarm;
        logic [31:0] d;
        bus_write(5'h08, 32'h0000_0003);
        mark = edges;
        bus_write(5'h04, 32'hFFFF_FFFE);
        bus_write(5'h00, 32'h0);
        bus_write(5'h10, 32'h3);
        wait_until(7);
        bus_read(5'h04, d); chk("R3 count at max", d, 32'hFFFF_FFFF);
        bus_read(5'h10, d); chk("R7 no alarm before match", d & 1, 0);
        wait_until(8);
        bus_read(5'h04, d); chk("R3 wrap to zero", d, 0);
        bus_read(5'h10, d); chk("R7 alarm on wrap match", d & 1, 1);
        chk("R11 irq_alarm masked", {31'b0, irq_alarm}, 0);
        bus_write(5'h10, 32'h4);
        chk("R11 irq_alarm enabled", {31'b0, irq_alarm}, 1);
        bus_read(5'h10, d); chk("R9 zero write keeps alarm flag", d & 1, 1);
        wait_until(12);
        bus_read(5'h10, d); chk("R7 alarm flag sticky", d & 1, 1);
        bus_write(5'h10, 32'h5);
        bus_read(5'h10, d); chk("R9 alarm flag cleared", d & 1, 0);
        chk("R11 irq_alarm drops", {31'b0, irq_alarm}, 0);
        wait_until(15);
        bus_write(5'h10, 32'h6);
        bus_read(5'h10, d); chk("R9 set wins over clear", (d >> 1) & 1, 1);
        bus_write(5'h00, 32'd50);
        bus_write(5'h04, 32'd50);
        bus_read(5'h10, d); chk("R7 load does not set alarm", d & 1, 0);
        wait_until(20);
        bus_read(5'h04, d); chk("R7 count past loaded match", d, 51);
        bus_read(5'h10, d); chk("R7 still no alarm", d & 1, 0);
        bus_write(5'h10, 32'hC);
        chk("R11 irq_tick enabled", {31'b0, irq_tick}, 1);
        bus_write(5'h10, 32'h3);
        chk("R11 irq_tick off", {31'b0, irq_tick}, 0);
    endtask

    task automatic t_trim(input logic [31:0] word, input int short_len, input string tag);
        logic [31:0] d;
        int last_edge;
        bus_write(5'h08, word);
        mark = edges;
        bus_write(5'h04, 32'h0);
        last_edge = 4092 + short_len;
        wait_until(4092);
        bus_read(5'h04, d); chk({tag, " 1023 full seconds"}, d, 1023);
        wait_until(last_edge - 1);
        bus_read(5'h04, d); chk({tag, " before short second ends"}, d, 1023);
        wait_until(last_edge);
        bus_read(5'h04, d); chk({tag, " short second ends"}, d, 1024);
        wait_until(last_edge + 4);
        bus_read(5'h04, d); chk({tag, " normal second after"}, d, 1025);
    endtask

    task automatic t_zero_write;
        logic [31:0] d;
        bus_write(5'h08, 32'h0);
        mark = edges;
        bus_write(5'h04, 32'h0);
        wait_until(32767);
        bus_read(5'h04, d); chk("R4 written zero before tick", d, 0);
        wait_until(32768);
        bus_read(5'h04, d); chk("R4 written zero tick", d, 1);
    endtask

    initial begin
        @(negedge clk);
        t_reset_default();
        t_map();
        t_period_load();
        t_alarm();
        t_trim(32'h0002_0003, 2, "R5 trim 2");
        t_trim(32'h000A_0003, 1, "R5 trim saturates");
        t_zero_write();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule